// File: doc/BRIEF.md
# CAN FD Reserved-Bit Exception Handler

This block watches the one bit of a received CAN FD frame that comes right after the FD format bit. That bit must be dominant. An external frame decoder supplies the sampled bit level and a bit-position strobe. The block then judges the bit. A dominant bit is normal, and the block can report that a recessive-to-dominant edge reference point was seen. A recessive bit has one of two outcomes, chosen by a configuration bit. The first is a plain form error. The second is a protocol exception sequence.

In the exception sequence the node stops counting errors, allows hard synchronization and drives only recessive bits. It stays in a bus integration state until it has sampled a run of consecutive recessive bits. The configuration bit is latched only while the decoder reports the bus idle, so it cannot change in the middle of a frame. Bit timing, CRC and frame decoding happen outside this block.

Top module: `canfd_pex_handler`

## Requirements
- R1: After reset, every output is low.
- R2: A reserved bit sampled dominant (`rx_bit_i`=0, with `sample_i` and `res_pos_i` high) produces no form-error pulse and no exception pulse.
- R3: With the latched exception-off setting at 1, a reserved bit sampled recessive (`rx_bit_i`=1) gives `form_err_o` high for exactly one cycle, in the cycle after that sample edge. No exception pulse and no integration follow.
- R4: With the latched exception-off setting at 0, a reserved bit sampled recessive gives `exc_event_o` high for exactly one cycle, in the cycle after that sample edge, and no form-error pulse.
- R5: From the cycle in which `exc_event_o` pulses, `bus_integ_o`, `tx_force_rec_o`, `hard_sync_en_o` and `ecnt_freeze_o` are all high.
- R6: Those four outputs go low in the cycle after the RUN_LEN-th consecutive recessive sample (default 11). A dominant sample restarts the count at zero.
- R7: `cfg_exc_off_i` is captured only on edges where `frame_idle_i` is high. A change during a frame has no effect on that frame's verdict.
- R8: A reserved-bit position is ignored when `sample_i` is low, and also while bus integration is active. No pulse results in either case.
- R9: `sync_ref_o` pulses for one cycle after a reserved bit is sampled dominant, provided the last FD format bit (`fdf_pos_i` with `sample_i`) was sampled recessive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| sample_i | input | 1 | Sample-point strobe, one cycle per bit |
| fdf_pos_i | input | 1 | Current bit is the FD format bit |
| res_pos_i | input | 1 | Current bit is the reserved bit after it |
| frame_idle_i | input | 1 | Decoder is between frames |
| cfg_exc_off_i | input | 1 | 1 = recessive reserved bit is a form error; 0 = exception sequence |
| form_err_o | output | 1 | Form-error pulse |
| exc_event_o | output | 1 | Protocol exception pulse |
| sync_ref_o | output | 1 | Valid edge reference pulse |
| hard_sync_en_o | output | 1 | Hard synchronization allowed |
| tx_force_rec_o | output | 1 | Transmitter forced recessive |
| ecnt_freeze_o | output | 1 | Error counters held |
| bus_integ_o | output | 1 | Bus integration in progress |

## Verification
The assertions check on every cycle that:
- the two verdict pulses never coincide;
- each verdict pulse lasts one cycle and follows a real reserved-bit sample;
- integration only begins with an exception pulse, and only ends on a recessive sample;
- the run counter stays below its limit;
- the latched setting moves only when the bus is idle.

The bench scenarios are what show the rest:
- the correct verdict for each combination of setting and bit levels;
- the exact length of the recessive run, including the restart on a dominant bit;
- that a setting changed in mid-frame is really ignored.

// File: rtl/canfd_pex_pkg.sv
package canfd_pex_pkg;

  typedef enum logic [1:0] {
    RB_NONE = 2'd0,
    RB_OK   = 2'd1,
    RB_FORM = 2'd2,
    RB_EXC  = 2'd3
  } rb_verdict_t;

  // Judge the reserved bit from its level, the setting and the phase.
  function automatic rb_verdict_t judge_bit(input logic hit, input logic rec,
                                            input logic exc_off, input logic integ);
    if (!hit || integ) return RB_NONE;
    if (!rec)          return RB_OK;
    if (exc_off)       return RB_FORM;
    return RB_EXC;
  endfunction

  // Recessive run length: grows on recessive, restarts on dominant.
  function automatic int unsigned run_step(input int unsigned cnt, input logic rec);
    return rec ? cnt + 1 : 0;
  endfunction

endpackage

// File: rtl/pex_cfg_hold.sv
module pex_cfg_hold #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic cfg_i,
  output logic cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= RST_VAL;
    else if (idle_i) cfg_q <= cfg_i;
  end
endmodule

// File: rtl/pex_resbit_judge.sv
module pex_resbit_judge
  import canfd_pex_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_i,
  input  logic        fdf_pos_i,
  input  logic        res_pos_i,
  input  logic        rx_i,
  input  logic        exc_off_i,
  input  logic        integ_i,
  output rb_verdict_t verdict_o,
  output logic        form_p_o,
  output logic        exc_p_o,
  output logic        sync_p_o
);
  logic fdf_rec_q;
  logic res_hit;

  assign res_hit   = sample_i && res_pos_i;
  assign verdict_o = judge_bit(res_hit, rx_i, exc_off_i, integ_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      fdf_rec_q <= 1'b0;
    else if (sample_i && fdf_pos_i)  fdf_rec_q <= rx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      form_p_o <= 1'b0;
      exc_p_o  <= 1'b0;
      sync_p_o <= 1'b0;
    end else begin
      form_p_o <= (verdict_o == RB_FORM);
      exc_p_o  <= (verdict_o == RB_EXC);
      sync_p_o <= (verdict_o == RB_OK) && fdf_rec_q;
    end
  end
endmodule

// File: rtl/pex_integ_tracker.sv
module pex_integ_tracker
  import canfd_pex_pkg::*;
#(
  parameter int unsigned RUN_LEN = 11,
  localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          sample_i,
  input  logic          rx_i,
  output logic          integ_o,
  output logic [CW-1:0] cnt_o
);
  localparam int unsigned LAST = RUN_LEN - 1;

  int unsigned nxt;
  assign nxt = run_step(int'(cnt_o), rx_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_o <= 1'b0;
      cnt_o   <= '0;
    end else if (start_i) begin
      integ_o <= 1'b1;
      cnt_o   <= '0;
    end else if (integ_o && sample_i) begin
      if (nxt > LAST) begin
        integ_o <= 1'b0;
        cnt_o   <= '0;
      end else begin
        cnt_o   <= CW'(nxt);
      end
    end
  end
endmodule

// File: rtl/canfd_pex_handler.sv
module canfd_pex_handler
  import canfd_pex_pkg::*;
#(
  parameter int unsigned RUN_LEN = 11,
  parameter logic        CFG_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit_i,
  input  logic sample_i,
  input  logic fdf_pos_i,
  input  logic res_pos_i,
  input  logic frame_idle_i,
  input  logic cfg_exc_off_i,
  output logic form_err_o,
  output logic exc_event_o,
  output logic sync_ref_o,
  output logic hard_sync_en_o,
  output logic tx_force_rec_o,
  output logic ecnt_freeze_o,
  output logic bus_integ_o
);
  localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;

  logic           cfg_exc_off_q;
  logic           integ;
  logic [CW-1:0]  integ_cnt;
  rb_verdict_t    verdict;
  logic           exc_start;

  pex_cfg_hold #(.RST_VAL(CFG_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .idle_i(frame_idle_i),
    .cfg_i(cfg_exc_off_i), .cfg_q(cfg_exc_off_q)
  );

  pex_resbit_judge u_judge (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .fdf_pos_i(fdf_pos_i),
    .res_pos_i(res_pos_i), .rx_i(rx_bit_i), .exc_off_i(cfg_exc_off_q),
    .integ_i(integ), .verdict_o(verdict), .form_p_o(form_err_o),
    .exc_p_o(exc_event_o), .sync_p_o(sync_ref_o)
  );

  assign exc_start = (verdict == RB_EXC);

  pex_integ_tracker #(.RUN_LEN(RUN_LEN)) u_integ (
    .clk(clk), .rst_n(rst_n), .start_i(exc_start), .sample_i(sample_i),
    .rx_i(rx_bit_i), .integ_o(integ), .cnt_o(integ_cnt)
  );

  assign bus_integ_o    = integ;
  assign tx_force_rec_o = integ;
  assign hard_sync_en_o = integ;
  assign ecnt_freeze_o  = integ;
endmodule

// File: rtl/canfd_pex_checker.sv
module canfd_pex_checker #(
  parameter int unsigned RUN_LEN = 11,
  localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_bit_i,
  input logic          sample_i,
  input logic          res_pos_i,
  input logic          frame_idle_i,
  input logic          form_err_o,
  input logic          exc_event_o,
  input logic          sync_ref_o,
  input logic          bus_integ_o,
  input logic [CW-1:0] integ_cnt,
  input logic          cfg_exc_off_q
);
  assert_pulse_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(form_err_o && exc_event_o));
  assert_form_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    form_err_o |=> !form_err_o);
  assert_form_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    form_err_o |-> $past(sample_i && res_pos_i && rx_bit_i));
  assert_exc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_event_o |=> !exc_event_o);
  assert_exc_integ_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_event_o |-> bus_integ_o);
  assert_integ_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_integ_o) |-> exc_event_o);
  assert_integ_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_integ_o) |-> $past(sample_i && rx_bit_i));
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(integ_cnt) < RUN_LEN);
  assert_cfg_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_exc_off_q) |-> $past(frame_idle_i));
  assert_no_form_integ_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_integ_o && !exc_event_o) |-> !form_err_o);
  assert_sync_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ref_o |-> $past(sample_i && res_pos_i && !rx_bit_i));
endmodule

bind canfd_pex_handler canfd_pex_checker #(.RUN_LEN(RUN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_bit_i(rx_bit_i), .sample_i(sample_i),
  .res_pos_i(res_pos_i), .frame_idle_i(frame_idle_i), .form_err_o(form_err_o),
  .exc_event_o(exc_event_o), .sync_ref_o(sync_ref_o), .bus_integ_o(bus_integ_o),
  .integ_cnt(integ_cnt), .cfg_exc_off_q(cfg_exc_off_q)
);

// File: tb/test_canfd_pex_handler.sv
`timescale 1ns/1ps
module test_canfd_pex_handler;
  localparam int RUN = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, smp = 1'b0, fdf = 1'b0, res = 1'b0, idle = 1'b1, cfg = 1'b0;
  logic form_err, exc_ev, sync_ref, hsync, txrec, freeze, integ;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  canfd_pex_handler #(.RUN_LEN(RUN)) i_canfd_pex_handler (
    .clk(clk), .rst_n(rst_n), .rx_bit_i(rx), .sample_i(smp), .fdf_pos_i(fdf),
    .res_pos_i(res), .frame_idle_i(idle), .cfg_exc_off_i(cfg),
    .form_err_o(form_err), .exc_event_o(exc_ev), .sync_ref_o(sync_ref),
    .hard_sync_en_o(hsync), .tx_force_rec_o(txrec), .ecnt_freeze_o(freeze),
    .bus_integ_o(integ)
  );

  // {cfg_off, fdf_level, res_level, exp_form, exp_exc, exp_sync}
  localparam logic [5:0] VEC [6] = '{
    6'b010_001, 6'b110_001, 6'b111_100,
    6'b011_010, 6'b000_000, 6'b101_100
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_integ(input string req, input logic exp);
    chk(req, integ, exp); chk(req, txrec, exp);
    chk(req, hsync, exp); chk(req, freeze, exp);
  endtask

  // Drive one bit for one cycle; returns at the next negedge with outputs updated.
  task automatic bit_cyc(input logic lvl, input logic s, input logic f, input logic r);
    rx = lvl; smp = s; fdf = f; res = r;
    @(negedge clk);
    smp = 0; fdf = 0; res = 0; rx = 1;
  endtask

  task automatic set_cfg(input logic c);
    idle = 1; cfg = c; @(negedge clk); idle = 0;
  endtask

  task automatic leave_integ();
    for (int k = 0; k < RUN; k++) bit_cyc(1, 1, 0, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 form", form_err, 0); chk("R1 exc", exc_ev, 0);
    chk("R1 sync", sync_ref, 0); chk_integ("R1 integ", 0);
    rst_n = 1; @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      set_cfg(VEC[i][5]);
      bit_cyc(VEC[i][4], 1, 1, 0);
      chk("R2 fdf bit quiet", form_err | exc_ev, 0);
      bit_cyc(VEC[i][3], 1, 0, 1);
      chk("R2/R3 form", form_err, VEC[i][2]);
      chk("R4 exc", exc_ev, VEC[i][1]);
      chk("R9 sync", sync_ref, VEC[i][0]);
      chk_integ("R5 integ", VEC[i][1]);
      bit_cyc(1, 0, 0, 0);
      chk("R3/R4 single pulse", form_err | exc_ev | sync_ref, 0);
      if (VEC[i][1]) begin
        leave_integ();
        chk_integ("R6 exit", 0);
      end
      idle = 1; @(negedge clk);
    end

    // R6: dominant restarts the run
    set_cfg(0);
    bit_cyc(1, 1, 1, 0); bit_cyc(1, 1, 0, 1);
    chk("R4 exc", exc_ev, 1);
    for (int k = 0; k < RUN - 1; k++) bit_cyc(1, 1, 0, 0);
    chk_integ("R6 still integ", 1);
    bit_cyc(0, 1, 0, 0);
    for (int k = 0; k < RUN - 1; k++) bit_cyc(1, 1, 0, 0);
    chk_integ("R6 restart", 1);
    // R8: reserved strobe during integration ignored
    bit_cyc(1, 0, 0, 0);
    bit_cyc(0, 0, 0, 0);
    bit_cyc(1, 1, 0, 1);
    chk("R8 integ form", form_err, 0); chk("R8 integ exc", exc_ev, 0);
    leave_integ();
    chk_integ("R6 exit after restart", 0);

    // R7: change of setting mid-frame ignored
    set_cfg(0);
    cfg = 1;
    bit_cyc(1, 1, 1, 0); bit_cyc(1, 1, 0, 1);
    chk("R7 exc kept", exc_ev, 1); chk("R7 no form", form_err, 0);
    leave_integ();
    idle = 1; @(negedge clk);

    // R8: reserved position without sample strobe ignored
    set_cfg(1);
    bit_cyc(1, 1, 1, 0); bit_cyc(1, 0, 0, 1);
    chk("R8 no strobe form", form_err, 0); chk("R8 no strobe exc", exc_ev, 0);
    chk_integ("R8 no strobe integ", 0);
    idle = 1; @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule